// File: doc/BRIEF.md
# Variable-Length Bit-Field Reader

This block pulls bit fields of 1 to 16 bits out of a packed bitstream held in word-addressed memory. A host sets a 24-bit byte start address and a control byte. The block fetches the 16-bit word at the current address and the word two bytes above it through a simple request/acknowledge read port. It then presents a 16-bit window of that 32-bit pair as a two-byte data register. The window starts at the current bit offset.

Stepping through a stream works like this. Each write of the control byte moves the stream forward by the field length. Optionally, when the automatic step is enabled, each read of the data high byte moves it forward as well. Any bit overflow past a word boundary is folded into a 2-byte address step. The updated address can be read back. Writing the start address rewinds the bit offset to zero and reloads the window without moving.

Top module: `vbit_reader`

## Requirements
- R1: After reset the address, control and data registers read zero, the bit offset is zero, `busy` is low and no memory request is raised.
- R2: A write to select 0, 1 or 2 replaces address bits 7:0, 15:8 or 23:16 respectively, clears the bit offset to zero and reloads the data window without moving the address.
- R3: A write to select 3 stores the control byte. Bits 3:0 are the field length, where 0 stands for 16. The write moves the stream forward by that length and reloads the data window.
- R4: A forward move forms s = length + offset. When s is 16 or more, the address grows by 2. The new offset is s mod 16. The new address reads back on selects 0 to 2.
- R5: The data window equals the low 16 bits of ({word at address+2, word at address} >> offset). Select 4 reads its bits 7:0 and select 5 reads its bits 15:8.
- R6: When control bit 7 is set, a read of select 5 returns the current high byte and then moves forward by the field length. When bit 7 is clear, reads never move the stream.
- R7: All address arithmetic, including the second word fetch, wraps modulo 2^24.
- R8: `busy` rises the cycle after an accepted command and stays high until the second word is received. Memory requests occur only while busy. A data read during busy returns the previous window.
- R9: While busy, register writes are ignored and a select-5 read does not move the stream.
- R10: Read data appears on `host_rdata` with `host_rvalid` one cycle after `host_re`. Selects 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 3 | Register select |
| host_we | input | 1 | Register write strobe |
| host_re | input | 1 | Register read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| host_rvalid | output | 1 | Read data valid |
| busy | output | 1 | Word fetches outstanding |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | 24 | Memory byte address of the requested word |
| mem_ack | input | 1 | Memory response valid |
| mem_rdata | input | 16 | Memory response word |

## Verification
A read result is due exactly one cycle after its strobe. The scoreboard monitor therefore pops an expectation whenever `host_rvalid` is seen at a falling edge. A refreshed window is due only after two memory handshakes, so its length depends on the memory's latency. The bench waits for `busy` to fall before it commits the new model window, and checks the old window by reading during that busy interval. `busy` itself is sampled at the first falling edge after the command edge.

// File: rtl/vbr_pkg.sv
package vbr_pkg;
  parameter int ADDR_W = 24;
  parameter int WORD_W = 16;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_LO   = 2'd1,
    F_HI   = 2'd2
  } fetch_st_t;

  // register selects; address bytes occupy selects 0..2 in ascending order
  localparam logic [2:0] SEL_CTRL = 3'd3;
  localparam logic [2:0] SEL_DLO  = 3'd4;
  localparam logic [2:0] SEL_DHI  = 3'd5;
endpackage

// File: rtl/vbr_advance.sv
module vbr_advance #(
  parameter int ADDR_W = 24,
  parameter int WORD_W = 16
) (
  input  logic [ADDR_W-1:0]          cur_addr,
  input  logic [$clog2(WORD_W)-1:0]  cur_pos,
  input  logic [$clog2(WORD_W)-1:0]  len_code,
  output logic [ADDR_W-1:0]          nxt_addr,
  output logic [$clog2(WORD_W)-1:0]  nxt_pos
);
  localparam int PW = $clog2(WORD_W);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);

  logic [PW:0] len_full;
  logic [PW:0] sum;

  always_comb begin
    // a zero length code stands for a full word
    len_full = (len_code == '0) ? (PW+1)'(WORD_W) : {1'b0, len_code};
    sum      = len_full + {1'b0, cur_pos};
    nxt_pos  = sum[PW-1:0];
    nxt_addr = cur_addr + (sum[PW] ? STEP : '0);
  end
endmodule

// File: rtl/vbr_fetch.sv
module vbr_fetch
  import vbr_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WORD_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [ADDR_W-1:0]          start_addr,
  input  logic [$clog2(WORD_W)-1:0]  start_shift,
  output logic                       busy,
  output logic [WORD_W-1:0]          data_q,
  output logic                       mem_req,
  output logic [ADDR_W-1:0]          mem_addr,
  input  logic                       mem_ack,
  input  logic [WORD_W-1:0]          mem_rdata
);
  localparam int PW = $clog2(WORD_W);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);

  fetch_st_t           st;
  logic [WORD_W-1:0]   lo_q;
  logic [PW-1:0]       sh_q;
  logic [ADDR_W-1:0]   a_q;
  logic [2*WORD_W-1:0] pair;

  assign pair     = {mem_rdata, lo_q} >> sh_q;
  assign busy     = (st != F_IDLE);
  assign mem_req  = (st != F_IDLE);
  assign mem_addr = a_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= F_IDLE;
      lo_q   <= '0;
      sh_q   <= '0;
      a_q    <= '0;
      data_q <= '0;
    end else begin
      case (st)
        F_IDLE: if (start) begin
          a_q  <= start_addr;
          sh_q <= start_shift;
          st   <= F_LO;
        end
        F_LO: if (mem_ack) begin
          lo_q <= mem_rdata;
          a_q  <= a_q + STEP;   // wraps at the address width
          st   <= F_HI;
        end
        F_HI: if (mem_ack) begin
          data_q <= pair[WORD_W-1:0];
          st     <= F_IDLE;
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  // request address held until the word arrives
  p_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_addr == $past(mem_addr)));

  // second fetch is the word two bytes above the first, wrapping
  p_second_word_r7: assert property (@(posedge clk) disable iff (rst)
    (st == F_LO && mem_ack) |=> (mem_addr == ADDR_W'($past(mem_addr) + STEP)));

  // window changes only on the second response
  p_window_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(st == F_HI && mem_ack) |=> $stable(data_q));
endmodule

// File: rtl/vbit_reader.sv
module vbit_reader
  import vbr_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        host_sel,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              host_rvalid,
  output logic              busy,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata
);
  localparam int PW = $clog2(WORD_W);
  localparam int NB = ADDR_W / 8;

  logic [ADDR_W-1:0] addr_q, addr_wr, nxt_addr, start_addr;
  logic [7:0]        ctrl_q;
  logic [PW-1:0]     pos_q, nxt_pos, len_code, start_shift;
  logic [WORD_W-1:0] data_q;
  logic              wr_addr, wr_ctrl, rd_step, advance, start;

  // command decode; nothing is accepted while fetches are outstanding
  always_comb begin
    wr_addr = host_we && !busy && (host_sel < 3'(NB));
    wr_ctrl = host_we && !busy && (host_sel == SEL_CTRL);
    rd_step = host_re && !host_we && !busy && (host_sel == SEL_DHI) && ctrl_q[7];
    advance = wr_ctrl || rd_step;
    start   = wr_addr || advance;
    len_code = wr_ctrl ? host_wdata[PW-1:0] : ctrl_q[PW-1:0];
  end

  always_comb begin
    addr_wr = addr_q;
    for (int k = 0; k < NB; k++)
      if (host_sel == 3'(k)) addr_wr[8*k +: 8] = host_wdata;
  end

  vbr_advance #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_adv (
    .cur_addr (addr_q),
    .cur_pos  (pos_q),
    .len_code (len_code),
    .nxt_addr (nxt_addr),
    .nxt_pos  (nxt_pos)
  );

  assign start_addr  = wr_addr ? addr_wr : nxt_addr;
  assign start_shift = wr_addr ? '0 : nxt_pos;

  vbr_fetch #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_fetch (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .start_addr  (start_addr),
    .start_shift (start_shift),
    .busy        (busy),
    .data_q      (data_q),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      ctrl_q <= '0;
      pos_q  <= '0;
    end else if (wr_addr) begin
      addr_q <= addr_wr;
      pos_q  <= '0;
    end else if (advance) begin
      addr_q <= nxt_addr;
      pos_q  <= nxt_pos;
      if (wr_ctrl) ctrl_q <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= host_re;
      if (host_re) begin
        case (host_sel)
          3'd0:     host_rdata <= addr_q[7:0];
          3'd1:     host_rdata <= addr_q[15:8];
          3'd2:     host_rdata <= addr_q[23:16];
          SEL_CTRL: host_rdata <= ctrl_q;
          SEL_DLO:  host_rdata <= data_q[7:0];
          SEL_DHI:  host_rdata <= data_q[15:8];
          default:  host_rdata <= '0;
        endcase
      end
    end
  end

  p_pos_clear_r2: assert property (@(posedge clk) disable iff (rst)
    wr_addr |=> (pos_q == '0));

  p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
    advance |=> ((addr_q == $past(addr_q)) ||
                 (addr_q == ADDR_W'($past(addr_q) + ADDR_W'(2)))));

  p_busy_follows_r8: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && host_we) |=> ($stable(addr_q) && $stable(ctrl_q) && $stable(pos_q)));

  p_rvalid_r10: assert property (@(posedge clk) disable iff (rst)
    host_re |=> host_rvalid);
endmodule

// File: tb/vbit_reader_tb.sv
module vbit_reader_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  host_sel;
  logic        host_we, host_re;
  logic [7:0]  host_wdata, host_rdata;
  logic        host_rvalid, busy, mem_req, mem_ack;
  logic [23:0] mem_addr;
  logic [15:0] mem_rdata;

  always #5 clk = ~clk;

  vbit_reader u_dut (
    .clk(clk), .rst(rst), .host_sel(host_sel), .host_we(host_we),
    .host_re(host_re), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .busy(busy), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  function automatic logic [15:0] wgen(input logic [23:0] a);
    return (a[15:0] * 16'd40503) ^ {a[23:16], a[7:0] ^ 8'hA5};
  endfunction

  // memory answers one cycle after seeing a request
  always @(posedge clk) begin
    if (rst) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack   <= mem_req && !mem_ack;
      mem_rdata <= wgen(mem_addr);
    end
  end

  // reference model
  logic [23:0] m_addr = '0;
  logic [7:0]  m_ctrl = '0;
  int          m_pos  = 0;
  logic [15:0] m_data = '0;
  logic [15:0] m_pend = '0;

  function automatic logic [15:0] window(input logic [23:0] a, input int p);
    logic [31:0] pr;
    pr = {wgen(a + 24'd2), wgen(a)};
    return 16'(pr >> p);
  endfunction

  task automatic m_advance(input logic [3:0] lc);
    int len;
    int s;
    len = (lc == 4'd0) ? 16 : int'(lc);
    s = len + m_pos;
    if (s >= 16) m_addr = m_addr + 24'd2;
    m_pos  = s % 16;
    m_pend = window(m_addr, m_pos);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always @(negedge clk) begin
    if (!rst && host_rvalid && !finished) begin
      if (exp_q.size() == 0) chk("R10 unexpected rvalid", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), {24'd0, host_rdata}, {24'd0, exp_q.pop_front()});
    end
  end

  task automatic do_wr(input logic [2:0] sel, input logic [7:0] val);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_wdata = val;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic do_rd(input logic [2:0] sel, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    host_re = 1'b1; host_sel = sel;
    @(negedge clk);
    host_re = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 1000) chk("R8 busy stuck", 32'd1, 32'd0);
    m_data = m_pend;
  endtask

  task automatic cmd_addr(input logic [2:0] sel, input logic [7:0] val);
    do_wr(sel, val);
    m_addr[8*sel +: 8] = val;
    m_pos  = 0;
    m_pend = window(m_addr, 0);
    wait_idle();
  endtask

  task automatic cmd_ctrl(input logic [7:0] val);
    do_wr(3'd3, val);
    m_ctrl = val;
    m_advance(val[3:0]);
    wait_idle();
  endtask

  task automatic check_state(input string tag);
    do_rd(3'd0, m_addr[7:0],   {tag, " addr0"});
    do_rd(3'd1, m_addr[15:8],  {tag, " addr1"});
    do_rd(3'd2, m_addr[23:16], {tag, " addr2"});
    do_rd(3'd4, m_data[7:0],   {tag, " R5 data lo"});
    if (!m_ctrl[7]) do_rd(3'd5, m_data[15:8], {tag, " R5 data hi"});
  endtask

  task automatic rd_hi_step(input string tag);
    do_rd(3'd5, m_data[15:8], tag);
    if (m_ctrl[7]) m_advance(m_ctrl[3:0]);
    wait_idle();
  endtask

  task automatic report();
    if (exp_q.size() != 0) chk("R10 missing read responses", exp_q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog expired", 32'd1, 32'd0);
    report();
  end

  initial begin
    rst = 1'b1; host_we = 1'b0; host_re = 1'b0; host_sel = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 mem_req", mem_req, 0);
    do_rd(3'd3, 8'h00, "R1 ctrl");
    check_state("R1");

    // R2 address byte writes refresh with zero offset
    cmd_addr(3'd0, 8'h34);
    cmd_addr(3'd1, 8'h12);
    cmd_addr(3'd2, 8'h05);
    check_state("R2");

    // R3/R4 control writes move forward
    cmd_ctrl(8'h05);
    check_state("R3 len5");
    do_rd(3'd3, 8'h05, "R3 ctrl readback");
    cmd_ctrl(8'h0C);
    check_state("R4 carry");
    cmd_ctrl(8'h00);
    check_state("R3 len16");

    // R6 auto step on high byte reads
    cmd_ctrl(8'h83);
    rd_hi_step("R6 auto1");
    rd_hi_step("R6 auto2");
    rd_hi_step("R6 auto3");
    check_state("R6 after auto");
    cmd_ctrl(8'h03);
    rd_hi_step("R6 no auto a");
    rd_hi_step("R6 no auto b");
    check_state("R6 no step");

    // R2 address write clears a nonzero offset
    cmd_addr(3'd0, 8'h90);
    check_state("R2 pos clear");

    // R7 wrap at 24 bits
    cmd_addr(3'd2, 8'hFF);
    cmd_addr(3'd1, 8'hFF);
    cmd_addr(3'd0, 8'hFE);
    check_state("R7 top");
    cmd_ctrl(8'h08);
    check_state("R7 straddle");
    cmd_ctrl(8'h08);
    check_state("R7 wrapped");

    // R8/R9 behaviour while busy
    do_wr(3'd3, 8'h01);
    m_ctrl = 8'h01;
    m_advance(4'd1);
    chk("R8 busy after command", busy, 1);
    host_we = 1'b1; host_sel = 3'd0; host_wdata = 8'h77;   // R9 ignored
    exp_q.push_back(m_data[7:0]);
    tag_q.push_back("R8 old window during busy");
    @(negedge clk);
    host_we = 1'b0;
    host_re = 1'b1; host_sel = 3'd4;
    @(negedge clk);
    host_re = 1'b0;
    wait_idle();
    check_state("R9 write ignored");

    cmd_ctrl(8'h82);
    do_wr(3'd3, 8'h82);
    m_advance(4'd2);
    exp_q.push_back(m_data[15:8]);
    tag_q.push_back("R9 hi read during busy");
    host_re = 1'b1; host_sel = 3'd5;                        // no extra step
    @(negedge clk);
    host_re = 1'b0;
    wait_idle();
    do_wr(3'd3, 8'h02);
    m_ctrl = 8'h02;
    m_advance(4'd2);
    wait_idle();
    check_state("R9 no extra step");

    // R10 unmapped selects
    do_rd(3'd6, 8'h00, "R10 sel6");
    do_rd(3'd7, 8'h00, "R10 sel7");
    repeat (3) @(negedge clk);
    report();
  end
endmodule